// File: doc/BRIEF.md
# Configurable Product-Term Logic Cluster

This block models one programmable logic cluster that sits on a larger routing fabric. Eighteen routed input signals feed an AND array of twenty-three product terms. Each term can connect to the true or the complement form of any input. Twenty of those terms form the data array, in four groups of five, one group per macrocell. The last three terms are control terms: one resets the registers, one produces the output enable, and one can serve as the cluster clock.

Each of the four macrocells chooses between two paths. The fast path ORs the first four terms of its own group. The wide path ORs any subset of all twenty data terms and XORs the result with either the fifth term of its group or a fixed polarity bit. The chosen value then goes out either directly or through a flip-flop. All flip-flops in the cluster share one clock. That clock is chosen from three global clocks or from the clock term. The four outputs are meant to be routed back into the fabric as inputs to other clusters.

The configuration is static. It is written one word at a time through a parallel port while `cfg_en` is high. During loading, the outputs and enables are forced low and the flip-flops are held cleared.

Top module: `ptlb_cluster`

## Requirements
- R1: Product term t is set by a 36-bit literal word. Bit 2k connects the true form of input k and bit 2k+1 connects its complement. The term is the AND of all connected literals, and a term with no literal connected is 0.
- R2: With macrocell flag bit 20 clear, the macrocell's path value is the OR of terms 5i to 5i+3 of its own group. Term 5i+4 and all other groups have no effect on it.
- R3: With flag bit 20 set, the path value is the OR of the data terms selected by mask bits 19:0, XORed with a second operand. That operand is term 5i+4 when bit 21 is set, and polarity bit 22 otherwise.
- R4: With flag bit 23 clear, the output follows the path value combinationally. With it set, the output is a flip-flop that loads the path value on each rising edge of the cluster clock and holds it between edges.
- R5: The clock-select word (address 27, bits 1:0) picks the cluster clock. Values 0, 1 and 2 pick global clock 0, 1 or 2, and value 3 picks control term 22. Edges on the clocks that are not picked do not change a registered output.
- R6: While `rst_n` is low, every flip-flop and every configuration word is cleared asynchronously, so all outputs and enables read 0.
- R7: While control term 20 is true, every registered output is held at 0 asynchronously. Combinational outputs are unaffected. Once the term goes false, the flip-flop reloads only at the next clock edge.
- R8: Outside loading, all four output enables equal control term 21.
- R9: On a rising `cfg_clk` edge with `cfg_en` and `cfg_we` high, `cfg_wdata` is written to the word at `cfg_addr`. Addresses 0 to 22 hold the term literals. Addresses 23 to 26 hold the flags of macrocells 0 to 3 (bits 23:0). While `cfg_en` is high, all outputs and enables read 0 and all flip-flops are held cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration write clock |
| rst_n | input | 1 | Active-low asynchronous reset of configuration and flip-flops |
| glb_clk | input | 3 | Three global clock candidates |
| cfg_en | input | 1 | Loading mode; forces outputs low and clears flip-flops |
| cfg_we | input | 1 | Write strobe for one configuration word |
| cfg_addr | input | 5 | Configuration word address |
| cfg_wdata | input | 36 | Configuration word data |
| in_sig | input | 18 | Routed inputs to the AND array |
| mc_out | output | 4 | Macrocell outputs, also for fabric feedback |
| mc_oe | output | 4 | Output enables from control term 21 |

## Verification
The checks assume that the configuration changes only while `cfg_en` is high, and that routed inputs change away from the rising edge of `cfg_clk`, so that combinational outputs have settled when the checker samples them. The bench changes every input on the falling edge of the 200 MHz clock. It pulses global clocks 1 and 2 by hand only after loading has finished. When the clock term is the cluster clock, it raises the clock input only after the data inputs of the registered macrocell have been stable for a while. That keeps the selected clock free of glitches and free of races with the flip-flop data.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
  typedef enum logic [1:0] {
    CLK_GLB0 = 2'd0,
    CLK_GLB1 = 2'd1,
    CLK_GLB2 = 2'd2,
    CLK_TERM = 2'd3
  } clk_src_e;

  // control terms follow the data terms, in this order
  localparam int CTRL_RST = 0;
  localparam int CTRL_OE  = 1;
  localparam int CTRL_CLK = 2;
  localparam int N_CTRL   = 3;

  // macrocell flag offsets above the sum mask
  localparam int FLG_WIDE = 0;
  localparam int FLG_XSRC = 1;
  localparam int FLG_POL  = 2;
  localparam int FLG_REG  = 3;
  localparam int N_FLAGS  = 4;
endpackage

// File: rtl/ptlb_cfg_store.sv
module ptlb_cfg_store #(
  parameter int LIT_W    = 36,
  parameter int N_PT     = 23,
  parameter int N_MC     = 4,
  parameter int MC_CFG_W = 24,
  parameter int AW       = 5
) (
  input  logic                       cfg_clk,
  input  logic                       rst_n,
  input  logic                       cfg_en,
  input  logic                       cfg_we,
  input  logic [AW-1:0]              cfg_addr,
  input  logic [LIT_W-1:0]           cfg_wdata,
  output logic [N_PT*LIT_W-1:0]      lits_flat,
  output logic [N_MC*MC_CFG_W-1:0]   mc_flat,
  output ptlb_pkg::clk_src_e         clk_src
);
  import ptlb_pkg::*;

  localparam int MC_BASE  = N_PT;
  localparam int CLK_ADDR = N_PT + N_MC;

  logic wr_ok;
  assign wr_ok = cfg_en & cfg_we;

  for (genvar t = 0; t < N_PT; t++) begin : g_term_word
    logic [LIT_W-1:0] word_q;
    always_ff @(posedge cfg_clk or negedge rst_n) begin
      if (!rst_n)                              word_q <= '0;
      else if (wr_ok && cfg_addr == AW'(t))    word_q <= cfg_wdata;
    end
    assign lits_flat[t*LIT_W +: LIT_W] = word_q;
  end

  for (genvar m = 0; m < N_MC; m++) begin : g_mc_word
    logic [MC_CFG_W-1:0] flags_q;
    always_ff @(posedge cfg_clk or negedge rst_n) begin
      if (!rst_n)                                      flags_q <= '0;
      else if (wr_ok && cfg_addr == AW'(MC_BASE + m))  flags_q <= cfg_wdata[MC_CFG_W-1:0];
    end
    assign mc_flat[m*MC_CFG_W +: MC_CFG_W] = flags_q;
  end

  always_ff @(posedge cfg_clk or negedge rst_n) begin
    if (!rst_n)                               clk_src <= CLK_GLB0;
    else if (wr_ok && cfg_addr == AW'(CLK_ADDR)) clk_src <= clk_src_e'(cfg_wdata[1:0]);
  end
endmodule

// File: rtl/ptlb_and_array.sv
module ptlb_and_array #(
  parameter int NUM_IN = 18,
  parameter int N_PT   = 23
) (
  input  logic [NUM_IN-1:0]          in_sig,
  input  logic [N_PT*2*NUM_IN-1:0]   lits_flat,
  output logic [N_PT-1:0]            pt
);
  localparam int LIT_W = 2 * NUM_IN;

  // AND of connected literals; an unconnected term reads 0
  function automatic logic term_eval(input logic [LIT_W-1:0] lits,
                                     input logic [NUM_IN-1:0] x);
    logic hit;
    hit = 1'b1;
    for (int k = 0; k < NUM_IN; k++) begin
      if (lits[2*k]   && !x[k]) hit = 1'b0;
      if (lits[2*k+1] &&  x[k]) hit = 1'b0;
    end
    return hit & (|lits);
  endfunction

  for (genvar t = 0; t < N_PT; t++) begin : g_term
    assign pt[t] = term_eval(lits_flat[t*LIT_W +: LIT_W], in_sig);
  end
endmodule

// File: rtl/ptlb_macrocell.sv
module ptlb_macrocell #(
  parameter int N_DATA_PT = 20,
  parameter int PT_PER_MC = 5,
  parameter int MC_IDX    = 0,
  parameter int MC_CFG_W  = 24
) (
  input  logic                  mc_clk,
  input  logic                  arst,
  input  logic                  cfg_hold,
  input  logic [N_DATA_PT-1:0]  pt_data,
  input  logic [MC_CFG_W-1:0]   cfg,
  output logic                  dout,
  output logic                  narrow_val,
  output logic                  path_val
);
  import ptlb_pkg::*;

  localparam int BASE     = MC_IDX * PT_PER_MC;
  localparam int NARROW_N = PT_PER_MC - 1;
  localparam int XOR_PT   = BASE + NARROW_N;

  logic [N_DATA_PT-1:0] sum_mask;
  logic wide_sel, xor_src, pol, reg_sel;
  logic wide_sum, xor_opnd, wide_val, q;

  assign sum_mask = cfg[N_DATA_PT-1:0];
  assign wide_sel = cfg[N_DATA_PT + FLG_WIDE];
  assign xor_src  = cfg[N_DATA_PT + FLG_XSRC];
  assign pol      = cfg[N_DATA_PT + FLG_POL];
  assign reg_sel  = cfg[N_DATA_PT + FLG_REG];

  assign narrow_val = |pt_data[BASE +: NARROW_N];
  assign wide_sum   = |(pt_data & sum_mask);
  assign xor_opnd   = xor_src ? pt_data[XOR_PT] : pol;
  assign wide_val   = wide_sum ^ xor_opnd;
  assign path_val   = wide_sel ? wide_val : narrow_val;

  always_ff @(posedge mc_clk or posedge arst) begin
    if (arst) q <= 1'b0;
    else      q <= path_val;
  end

  assign dout = cfg_hold ? 1'b0 : (reg_sel ? q : path_val);
endmodule

// File: rtl/ptlb_cluster.sv
module ptlb_cluster #(
  parameter int NUM_IN    = 18,
  parameter int N_MC      = 4,
  parameter int PT_PER_MC = 5,
  parameter int CFG_AW    = $clog2(N_MC*PT_PER_MC + ptlb_pkg::N_CTRL + N_MC + 1)
) (
  input  logic                 cfg_clk,
  input  logic                 rst_n,
  input  logic [2:0]           glb_clk,
  input  logic                 cfg_en,
  input  logic                 cfg_we,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [2*NUM_IN-1:0]  cfg_wdata,
  input  logic [NUM_IN-1:0]    in_sig,
  output logic [N_MC-1:0]      mc_out,
  output logic [N_MC-1:0]      mc_oe
);
  import ptlb_pkg::*;

  localparam int LIT_W     = 2 * NUM_IN;
  localparam int N_DATA_PT = N_MC * PT_PER_MC;
  localparam int N_PT      = N_DATA_PT + N_CTRL;
  localparam int MC_CFG_W  = N_DATA_PT + N_FLAGS;

  logic [N_PT*LIT_W-1:0]     lits_flat;
  logic [N_MC*MC_CFG_W-1:0]  mc_flat;
  clk_src_e                  clk_src;
  logic [N_PT-1:0]           pt_all;

  // named internal events
  logic term_rst, term_oe, term_clk;
  logic reg_async_clr, cluster_clk;
  logic [N_MC-1:0] narrow_vec, path_vec, reg_mask, wide_mask;

  ptlb_cfg_store #(
    .LIT_W(LIT_W), .N_PT(N_PT), .N_MC(N_MC), .MC_CFG_W(MC_CFG_W), .AW(CFG_AW)
  ) u_cfg (
    .cfg_clk(cfg_clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .lits_flat(lits_flat), .mc_flat(mc_flat), .clk_src(clk_src)
  );

  ptlb_and_array #(.NUM_IN(NUM_IN), .N_PT(N_PT)) u_and (
    .in_sig(in_sig), .lits_flat(lits_flat), .pt(pt_all)
  );

  assign term_rst = pt_all[N_DATA_PT + CTRL_RST];
  assign term_oe  = pt_all[N_DATA_PT + CTRL_OE];
  assign term_clk = pt_all[N_DATA_PT + CTRL_CLK];

  assign reg_async_clr = ~rst_n | term_rst | cfg_en;

  always_comb begin
    case (clk_src)
      CLK_GLB0: cluster_clk = glb_clk[0];
      CLK_GLB1: cluster_clk = glb_clk[1];
      CLK_GLB2: cluster_clk = glb_clk[2];
      default:  cluster_clk = term_clk;
    endcase
  end

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    logic [MC_CFG_W-1:0] cfg_m;
    assign cfg_m        = mc_flat[m*MC_CFG_W +: MC_CFG_W];
    assign reg_mask[m]  = cfg_m[N_DATA_PT + FLG_REG];
    assign wide_mask[m] = cfg_m[N_DATA_PT + FLG_WIDE];

    ptlb_macrocell #(
      .N_DATA_PT(N_DATA_PT), .PT_PER_MC(PT_PER_MC), .MC_IDX(m), .MC_CFG_W(MC_CFG_W)
    ) u_mc (
      .mc_clk(cluster_clk), .arst(reg_async_clr), .cfg_hold(cfg_en),
      .pt_data(pt_all[N_DATA_PT-1:0]), .cfg(cfg_m),
      .dout(mc_out[m]), .narrow_val(narrow_vec[m]), .path_val(path_vec[m])
    );
  end

  assign mc_oe = cfg_en ? '0 : {N_MC{term_oe}};
endmodule

// File: rtl/ptlb_cluster_chk.sv
module ptlb_cluster_chk #(
  parameter int N_MC = 4
) (
  input logic            cfg_clk,
  input logic            rst_n,
  input logic            cfg_en,
  input logic [N_MC-1:0] mc_out,
  input logic [N_MC-1:0] mc_oe,
  input logic            term_rst,
  input logic            term_oe,
  input logic [N_MC-1:0] reg_mask,
  input logic [N_MC-1:0] wide_mask,
  input logic [N_MC-1:0] narrow_vec,
  input logic [N_MC-1:0] path_vec
);
  logic [N_MC-1:0] comb_live, narrow_live;
  assign comb_live   = cfg_en ? '0 : ~reg_mask;
  assign narrow_live = comb_live & ~wide_mask;

  // R9
  load_hold_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    cfg_en |-> (mc_out == '0 && mc_oe == '0));

  // R8
  oe_term_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (!cfg_en && term_oe) |-> (&mc_oe));

  // R7
  term_reset_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    term_rst |-> ((mc_out & reg_mask) == '0));

  // R4
  comb_follow_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    1'b1 |-> ((mc_out & comb_live) == (path_vec & comb_live)));

  // R2
  narrow_path_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    1'b1 |-> ((mc_out & narrow_live) == (narrow_vec & narrow_live)));
endmodule

bind ptlb_cluster ptlb_cluster_chk #(.N_MC(N_MC)) u_chk (
  .cfg_clk(cfg_clk), .rst_n(rst_n), .cfg_en(cfg_en),
  .mc_out(mc_out), .mc_oe(mc_oe),
  .term_rst(term_rst), .term_oe(term_oe),
  .reg_mask(reg_mask), .wide_mask(wide_mask),
  .narrow_vec(narrow_vec), .path_vec(path_vec)
);

// File: tb/tb_ptlb_cluster.sv
`timescale 1ns/1ps
module tb_ptlb_cluster;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        g1 = 1'b0, g2 = 1'b0;
  logic        cfg_en = 1'b0, cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [35:0] cfg_wdata = '0;
  logic [17:0] in_sig = '0;
  logic [3:0]  mc_out, mc_oe;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ptlb_cluster dut (
    .cfg_clk(clk), .rst_n(rst_n), .glb_clk({g2, g1, clk}),
    .cfg_en(cfg_en), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_sig(in_sig), .mc_out(mc_out), .mc_oe(mc_oe)
  );

  // stimulus / expected: inputs, outputs 2:0 (combinational macrocells), enable level
  localparam int NV = 12;
  localparam logic [17:0] VIN [NV] = '{18'h00000, 18'h00004, 18'h00007, 18'h0000C,
                                        18'h0001C, 18'h00024, 18'h000C4, 18'h00044,
                                        18'h00104, 18'h20004, 18'h20104, 18'h04004};
  localparam logic [2:0]  VOUT[NV] = '{3'b011, 3'b010, 3'b001, 3'b011,
                                        3'b010, 3'b000, 3'b000, 3'b010,
                                        3'b110, 3'b110, 3'b010, 3'b010};
  localparam logic        VOE [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
                                        1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [35:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_clk_src(input logic [1:0] s);
    @(negedge clk); cfg_en = 1'b1;
    wr(5'd27, {34'd0, s});
    @(negedge clk); cfg_en = 1'b0;
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 reset out", mc_out, 4'b0000);
    chk("R6 reset oe", mc_oe, 4'b0000);
    rst_n = 1'b1;

    // load configuration
    @(negedge clk); cfg_en = 1'b1;
    wr(5'd0,  36'h5);           // in0 & in1
    wr(5'd1,  36'h20);          // ~in2
    wr(5'd3,  36'h240);         // in3 & ~in4
    wr(5'd5,  36'h400);         // in5
    wr(5'd6,  36'h5000);        // in6 & in7
    wr(5'd10, 36'h1_0000);      // in8
    wr(5'd14, 36'h4_0000_0000); // in17 (xor term of mc2)
    wr(5'd15, 36'h4_0000);      // in9
    wr(5'd16, 36'h50_0000);     // in10 & in11
    wr(5'd20, 36'h500_0000);    // reset term: in12 & in13
    wr(5'd21, 36'h2000_0000);   // enable term: ~in14
    wr(5'd22, 36'h4000_0000);   // clock term: in15
    wr(5'd24, 36'h50_0061);     // mc1 wide, polarity 1
    wr(5'd25, 36'h30_0400);     // mc2 wide, xor term
    wr(5'd26, 36'h80_0000);     // mc3 narrow, registered
    wr(5'd27, 36'h0);
    #1;
    chk("R9 hold out while loading", mc_out, 4'b0000);
    chk("R9 hold oe while loading", mc_oe, 4'b0000);
    @(negedge clk); cfg_en = 1'b0;
    #1;
    chk("R9 out after loading", mc_out, 4'b0011);

    // R1 R2 R3 R8 vector walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk); in_sig = VIN[i];
      #1;
      chk($sformatf("R1 R2 R3 vector %0d", i), {1'b0, mc_out[2:0]}, {1'b0, VOUT[i]});
      chk($sformatf("R8 vector %0d", i), mc_oe, {4{VOE[i]}});
    end

    // R4 registered output
    @(negedge clk); in_sig = 18'h00200;
    #1 chk("R4 before edge", {3'b0, mc_out[3]}, 4'b0000);
    @(negedge clk); chk("R4 after edge", {3'b0, mc_out[3]}, 4'b0001);
    in_sig = 18'h00000;
    #1 chk("R4 hold", {3'b0, mc_out[3]}, 4'b0001);
    @(negedge clk); chk("R4 reload", {3'b0, mc_out[3]}, 4'b0000);
    in_sig = 18'h00C00;
    @(negedge clk); chk("R4 second term", {3'b0, mc_out[3]}, 4'b0001);

    // R7 term reset
    in_sig = 18'h00200;
    @(negedge clk); in_sig = 18'h03200;
    #1 chk("R7 term reset", mc_out, 4'b0011);
    @(negedge clk); in_sig = 18'h00200;
    #1 chk("R7 no reload before edge", {3'b0, mc_out[3]}, 4'b0000);
    @(negedge clk); chk("R7 reload at edge", {3'b0, mc_out[3]}, 4'b0001);

    // R5 clock selection
    set_clk_src(2'd1);
    in_sig = 18'h00200;
    repeat (3) @(negedge clk);
    chk("R5 glb0 ignored", {3'b0, mc_out[3]}, 4'b0000);
    g1 = 1'b1; #1;
    chk("R5 glb1 edge", {3'b0, mc_out[3]}, 4'b0001);
    g1 = 1'b0;
    @(negedge clk); in_sig = 18'h00000;
    g2 = 1'b1; #1 g2 = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 glb0 glb2 ignored", {3'b0, mc_out[3]}, 4'b0001);
    set_clk_src(2'd3);
    in_sig = 18'h00200;
    repeat (2) @(negedge clk);
    chk("R5 term clock idle", {3'b0, mc_out[3]}, 4'b0000);
    in_sig = 18'h08200;
    #1 chk("R5 term clock edge", {3'b0, mc_out[3]}, 4'b0001);

    // R6 reset clears flip-flops and configuration
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R6 reset out", mc_out, 4'b0000);
    chk("R6 reset oe", mc_oe, 4'b0000);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule